// File: doc/BRIEF.md
# SMBus Packet Error Code Unit

This block keeps a running CRC-8 over every byte of one SMBus transaction as the byte tracker beside the bus hands it bytes. The tracker raises a one-cycle strobe with each byte. It also flags the byte that is the trailing check byte, and it pulses a clear when a new transaction opens with a START. A repeated START is not a new transaction. The tracker does not clear the unit there, so the second address byte and everything after it land in the same remainder.

In generate mode a bus master reads `pec_value` after the last payload byte and appends it as the check byte just before the STOP. In check mode the receiver flags the arriving check byte. The unit folds that byte into the remainder, and a zero remainder means the check byte matched. The unit then reports either a match or a mismatch, and the owner can retry the transfer after a mismatch.

Top module: `smbus_pec_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `pec_value` = 0x00 and `res_valid`, `res_match` and `res_mismatch` all at 0.
- R2: Each `byte_valid` strobe folds `byte_data` into the remainder. The CRC uses generator 0x07 (x^8+x^2+x+1) and processes the byte most significant bit first, with no reflection and no final XOR. The new remainder appears on `pec_value` in the cycle after the strobe. For example, the ASCII bytes "123456789" taken from a zero start give 0xF4.
- R3: A `txn_clear` without a strobe sets `pec_value` to 0x00 in the next cycle and zeroes both verdict outputs.
- R4: A `txn_clear` in the same cycle as a strobe starts the remainder from 0x00 and folds that byte in. The next cycle shows the CRC of that single byte.
- R5: In a cycle with neither strobe nor clear, `pec_value` and both verdict outputs keep their values, and `res_valid` is 0.
- R6: In check mode (`check_mode`=1), a strobe with `is_check_byte`=1 pulses `res_valid` for exactly the next cycle. In that cycle `res_match`=1 if the remainder after folding in the check byte is 0x00. Otherwise `res_mismatch`=1. The two are never high together.
- R7: The verdict outputs hold until the next clear or the next check-mode check byte.
- R8: In generate mode (`check_mode`=0), a strobe with `is_check_byte`=1 still folds the byte in. It raises no `res_valid` and leaves `res_match` and `res_mismatch` unchanged. Appending `pec_value` therefore leaves a remainder of 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_clear | input | 1 | New transaction (START, not repeated START): restart remainder at zero |
| byte_valid | input | 1 | One-cycle strobe: `byte_data` holds a completed bus byte |
| byte_data | input | 8 | Byte seen on the bus |
| is_check_byte | input | 1 | Marks the strobed byte as the trailing check byte |
| check_mode | input | 1 | 1 = check received check byte, 0 = generate check byte |
| pec_value | output | 8 | Current CRC remainder; the byte to append in generate mode |
| res_valid | output | 1 | One-cycle pulse: verdict updated |
| res_match | output | 1 | Last checked check byte matched |
| res_mismatch | output | 1 | Last checked check byte did not match |

## Verification
The bench targets the clear that arrives together with the first address byte. A design that folded the byte into the old remainder would give a wrong first value. It runs long random transactions with no mid-transaction clear, which exposes any design that drops bytes or resets at a repeated START. It also runs the standard nine-byte vector, which catches a design with reflected bits, a wrong polynomial or a final XOR. Corrupted and correct check bytes in check mode, and an appended check byte in generate mode, expose a swapped verdict and a spurious verdict pulse. They also expose a verdict that fails to hold between transactions.

// File: rtl/smbus_pec_pkg.sv
// Package: shared constants and types for the SMBus packet error code unit.
// Assumes the SMBus CRC-8 (generator 0x07, zero initial value).
package smbus_pec_pkg;

    localparam int          PEC_W_DEF    = 8;
    localparam int          DATA_W_DEF   = 8;
    localparam logic [7:0]  PEC_POLY_DEF = 8'h07;
    localparam logic [7:0]  PEC_INIT_DEF = 8'h00;

    // Verdict state carried between transactions.
    typedef struct packed {
        logic valid;
        logic match;
        logic mismatch;
    } pec_verdict_t;

endpackage

// File: rtl/pec_byte_step.sv
// Module: pec_byte_step
// Purely combinational: folds one DATA_W-bit word into a PEC_W-bit CRC
// remainder, most significant data bit first, as a chain of DATA_W
// single-bit shift stages. Assumes no reflection and no final XOR.
module pec_byte_step #(
    parameter int              PEC_W  = 8,
    parameter int              DATA_W = 8,
    parameter logic [PEC_W-1:0] POLY  = 8'h07
) (
    input  logic [PEC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [PEC_W-1:0]  crc_out
);

    // stage[k] holds the remainder after k data bits have been folded in
    logic [PEC_W-1:0] stage [DATA_W+1];

    // Seed the chain with the incoming remainder.
    always_comb stage[0] = crc_in;

    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
        logic feedback;
        // Feedback is the remainder MSB against the next data bit (MSB first).
        always_comb feedback = stage[k][PEC_W-1] ^ data_in[DATA_W-1-k];
        // Shift left and apply the generator when feedback is set.
        always_comb stage[k+1] = {stage[k][PEC_W-2:0], 1'b0} ^ (feedback ? POLY : '0);
    end

    // Result after the full word.
    always_comb crc_out = stage[DATA_W];

endmodule

// File: rtl/pec_accum.sv
// Module: pec_accum
// Holds the running remainder of one transaction. A clear restarts from
// INIT; a clear with a strobe folds that byte into INIT. Assumes the caller
// clears only at a START, never at a repeated START.
module pec_accum #(
    parameter int               PEC_W  = 8,
    parameter int               DATA_W = 8,
    parameter logic [PEC_W-1:0] POLY   = 8'h07,
    parameter logic [PEC_W-1:0] INIT   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data,
    output logic [PEC_W-1:0]  crc_q,
    output logic [PEC_W-1:0]  crc_next
);

    logic [PEC_W-1:0] seed;

    // Pick the starting remainder: fresh on a clear, else the running value.
    always_comb seed = clr ? INIT : crc_q;

    pec_byte_step #(
        .PEC_W  (PEC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) u_step (
        .crc_in  (seed),
        .data_in (data),
        .crc_out (crc_next)
    );

    // Register the remainder: reset, fold a byte, clear, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= INIT;
        else if (strobe) crc_q <= crc_next;
        else if (clr)    crc_q <= INIT;
    end

endmodule

// File: rtl/pec_verdict.sv
// Module: pec_verdict
// Turns the remainder after a check-mode check byte into a one-cycle valid
// pulse plus sticky match/mismatch flags. Assumes crc_next is the remainder
// that already includes the strobed byte.
module pec_verdict #(
    parameter int PEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             strobe,
    input  logic             is_check,
    input  logic             check_mode,
    input  logic [PEC_W-1:0] crc_next,
    output logic             res_valid,
    output logic             res_match,
    output logic             res_mismatch
);
    import smbus_pec_pkg::*;

    pec_verdict_t v_q;
    logic         judge;
    logic         zero_rem;

    // A verdict is due only for a check byte while checking.
    always_comb judge = strobe && is_check && check_mode;

    // A zero remainder after the check byte means the codes agreed.
    always_comb zero_rem = (crc_next == '0);

    // Update verdict state: judge beats clear, clear beats hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else if (judge) begin
            v_q.valid    <= 1'b1;
            v_q.match    <= zero_rem;
            v_q.mismatch <= !zero_rem;
        end else if (clr) begin
            v_q <= '0;
        end else begin
            v_q.valid <= 1'b0;
        end
    end

    // Drive the outputs from the verdict state.
    always_comb begin
        res_valid    = v_q.valid;
        res_match    = v_q.match;
        res_mismatch = v_q.mismatch;
    end

endmodule

// File: rtl/smbus_pec_unit.sv
// Module: smbus_pec_unit (top)
// Running SMBus packet error code over a whole transaction. It generates the
// check byte for a master or checks a received one. Assumes a byte tracker
// supplies one strobe per completed byte and a clear at each START only.
module smbus_pec_unit #(
    parameter int         PEC_W  = smbus_pec_pkg::PEC_W_DEF,
    parameter int         DATA_W = smbus_pec_pkg::DATA_W_DEF,
    parameter logic [7:0] POLY   = smbus_pec_pkg::PEC_POLY_DEF,
    parameter logic [7:0] INIT   = smbus_pec_pkg::PEC_INIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_clear,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              is_check_byte,
    input  logic              check_mode,
    output logic [PEC_W-1:0]  pec_value,
    output logic              res_valid,
    output logic              res_match,
    output logic              res_mismatch
);

    localparam logic [PEC_W-1:0] POLY_W = POLY[PEC_W-1:0];
    localparam logic [PEC_W-1:0] INIT_W = INIT[PEC_W-1:0];

    logic [PEC_W-1:0] crc_next;

    pec_accum #(
        .PEC_W  (PEC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY_W),
        .INIT   (INIT_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (txn_clear),
        .strobe   (byte_valid),
        .data     (byte_data),
        .crc_q    (pec_value),
        .crc_next (crc_next)
    );

    pec_verdict #(
        .PEC_W (PEC_W)
    ) u_verdict (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (txn_clear),
        .strobe       (byte_valid),
        .is_check     (is_check_byte),
        .check_mode   (check_mode),
        .crc_next     (crc_next),
        .res_valid    (res_valid),
        .res_match    (res_match),
        .res_mismatch (res_mismatch)
    );

endmodule

// File: rtl/smbus_pec_unit_sva.sv
// Module: smbus_pec_unit_sva
// Assertion checker bound to smbus_pec_unit; observes ports only.
module smbus_pec_unit_sva #(
    parameter int PEC_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_clear,
    input logic              byte_valid,
    input logic [DATA_W-1:0] byte_data,
    input logic              is_check_byte,
    input logic              check_mode,
    input logic [PEC_W-1:0]  pec_value,
    input logic              res_valid,
    input logic              res_match,
    input logic              res_mismatch
);

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        txn_clear && !byte_valid |=> pec_value == '0 && !res_match && !res_mismatch); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_clear && !byte_valid |=> $stable(pec_value) && $stable(res_match)
                                      && $stable(res_mismatch) && !res_valid); // R5

    AST_CHECK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && is_check_byte && check_mode |=> res_valid); // R6

    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_match && res_mismatch)); // R6

    AST_MATCH_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_match == (pec_value == '0)) && (res_mismatch != res_match)); // R6

    AST_GEN_NO_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && is_check_byte && !check_mode && !txn_clear
        |=> !res_valid && $stable(res_match) && $stable(res_mismatch)); // R8

endmodule

bind smbus_pec_unit smbus_pec_unit_sva #(
    .PEC_W  (PEC_W),
    .DATA_W (DATA_W)
) u_sva (.*);

// File: tb/smbus_pec_unit_test.sv
// Bench: smbus_pec_unit_test
// Random SMBus-like transactions mixed with directed corner cases, checked
// against a bench-side CRC-8 model.
module smbus_pec_unit_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_clear = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       is_check_byte = 1'b0;
    logic       check_mode = 1'b0;
    logic [7:0] pec_value;
    logic       res_valid;
    logic       res_match;
    logic       res_mismatch;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [7:0] m_crc = 8'h00;
    logic       m_match = 1'b0;
    logic       m_bad = 1'b0;
    logic       m_vld = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_pec_unit uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .txn_clear     (txn_clear),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .is_check_byte (is_check_byte),
        .check_mode    (check_mode),
        .pec_value     (pec_value),
        .res_valid     (res_valid),
        .res_match     (res_match),
        .res_mismatch  (res_mismatch)
    );

    // Reference CRC-8, generator 0x07, MSB first.
    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++)
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic check_all(input string tag);
        checks++;
        if (pec_value !== m_crc || res_valid !== m_vld ||
            res_match !== m_match || res_mismatch !== m_bad) begin
            errors++;
            $display("FAIL %s: got pec=%02h vld=%0b m=%0b x=%0b, expected pec=%02h vld=%0b m=%0b x=%0b",
                     tag, pec_value, res_valid, res_match, res_mismatch,
                     m_crc, m_vld, m_match, m_bad);
        end
    endtask

    // One cycle of stimulus, then check the cycle after.
    task automatic step(input logic clr, input logic vld, input logic [7:0] d,
                        input logic chk_byte, input logic mode, input string tag);
        logic [7:0] nxt;
        txn_clear = clr; byte_valid = vld; byte_data = d;
        is_check_byte = chk_byte; check_mode = mode;
        nxt = ref_crc(clr ? 8'h00 : m_crc, d);
        m_vld = 1'b0;
        if (vld && chk_byte && mode) begin
            m_vld = 1'b1; m_match = (nxt == 8'h00); m_bad = (nxt != 8'h00);
        end else if (clr) begin
            m_match = 1'b0; m_bad = 1'b0;
        end
        if (vld) m_crc = nxt;
        else if (clr) m_crc = 8'h00;
        @(negedge clk);
        txn_clear = 1'b0; byte_valid = 1'b0; is_check_byte = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] seq [9];
        logic [7:0] pv;
        int nb;
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset state");

        // R2: standard nine-byte vector
        seq = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
        for (int i = 0; i < 9; i++) step(i == 0, 1'b1, seq[i], 1'b0, 1'b1, "R2 vector byte");
        checks++;
        if (pec_value !== 8'hF4) begin
            errors++; $display("FAIL R2 vector: got %02h expected f4", pec_value);
        end

        // R5: idle cycles hold
        step(1'b0, 1'b0, 8'hAA, 1'b0, 1'b1, "R5 idle hold");
        step(1'b0, 1'b0, 8'h55, 1'b1, 1'b1, "R5 idle hold with flags");

        // R3: clear alone
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R3 clear alone");

        // R4: clear with first byte; single 0x01 gives 0x07
        step(1'b1, 1'b1, 8'h01, 1'b0, 1'b1, "R4 clear with byte");
        checks++;
        if (pec_value !== 8'h07) begin
            errors++; $display("FAIL R4 single byte: got %02h expected 07", pec_value);
        end

        // R6 match, then R7 hold, then R8 generate-mode append leaves verdict
        pv = m_crc;
        step(1'b0, 1'b1, pv, 1'b1, 1'b1, "R6 correct check byte");
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R7 verdict holds");
        step(1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, "R7 verdict holds over byte");
        pv = m_crc;
        step(1'b0, 1'b1, pv, 1'b1, 1'b0, "R8 generate append no verdict");
        checks++;
        if (pec_value !== 8'h00) begin
            errors++; $display("FAIL R8 append remainder: got %02h expected 00", pec_value);
        end

        // R6 mismatch
        step(1'b1, 1'b1, 8'hA6, 1'b0, 1'b1, "R4 new transaction");
        step(1'b0, 1'b1, m_crc ^ 8'h10, 1'b1, 1'b1, "R6 corrupted check byte");

        // Reset mid-stream
        rst_n = 1'b0;
        @(negedge clk);
        m_crc = 8'h00; m_vld = 1'b0; m_match = 1'b0; m_bad = 1'b0;
        check_all("R1 reset after use");
        rst_n = 1'b1;

        // Random transactions with a repeated-start style second address byte
        for (int t = 0; t < 400; t++) begin
            logic mode;
            mode = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) step(1'b1, 1'b0, 8'h00, 1'b0, mode, "R3 random clear");
            step(1'b1, 1'b1, 8'($urandom), 1'b0, mode, "R4 random first byte");
            nb = $urandom_range(1, 6);
            for (int b = 0; b < nb; b++) begin
                if ($urandom_range(0, 2) == 0) step(1'b0, 1'b0, 8'($urandom), 1'b0, mode, "R5 random gap");
                step(1'b0, 1'b1, 8'($urandom), 1'b0, mode, "R2 random byte");
            end
            pv = m_crc;
            if (mode && $urandom_range(0, 2) == 0) pv = pv ^ 8'($urandom_range(1, 255));
            step(1'b0, 1'b1, pv, 1'b1, mode, mode ? "R6 random check byte" : "R8 random append");
            step(1'b0, 1'b0, 8'h00, 1'b0, mode, "R7 random verdict hold");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule